// File: doc/BRIEF.md
# Link Speed-Change Stall Monitor

This block supervises link bring-up after training has been enabled. On a start strobe it polls the training status. The link is declared up once the status shows an established link that is no longer training. While the link is not yet up, each poll reads a receiver status register in the PHY. That reading, together with the training state machine's current state, tells the block whether a speed change is stuck in receiver-lock recovery.

A stall is recovered by a timed pulse. The block turns on the PHY's receiver data and PLL overrides with a read-modify-write, keeps them on for a fixed hold time, and then turns them off with a second read-modify-write. Polls are spaced by a fixed interval. If the link has not come up after a bounded number of polls, the block raises a sticky timeout error.

PHY registers are reached through a single-outstanding request/done port. All intervals come from a cycle counter scaled by a ticks-per-microsecond parameter.

Top module: `link_stall_recovery`

## Requirements
- R1: The link is declared up (`link_up` = 1) only on a poll that sees `dbg1[4]` = 1 and `dbg1[29]` = 0. When that happens, no PHY access is made for that poll.
- R2: Every poll that does not find the link up issues exactly one read of the PHY status register at address `STAT_ADDR` (default 16'h100D).
- R3: Recovery runs only when bit 0 of the status read data is 0 and `dbg0[5:0]` equals 6'h0D. The upper bits of `dbg0` play no part in the decision. In every other case the poll ends after the status read.
- R4: Recovery first reads the override register at `OVR_ADDR` (default 16'h1005). It then writes back the read value with bits 5 and 3 set (OR with 16'h0028).
- R5: After the setting write, the block waits at least `HOLD_US*TICKS_PER_US` cycles. It then reads the override register again and writes back that value with bits 5 and 3 cleared.
- R6: Consecutive status reads within one run are at least `POLL_US*TICKS_PER_US` cycles apart.
- R7: After `MAX_POLLS` polls without link-up, `link_err` is set and polling stops. `link_up` and `link_err` are never both 1.
- R8: `link_up` and `link_err` are sticky until the next accepted start. A start strobe is accepted only when the block is idle; accepting it clears both flags and begins a new run. A start during a run has no effect.
- R9: `phy_req` stays high, with address, direction and write data stable, until the cycle `phy_done` is seen. At most one PHY access is outstanding at a time.
- R10: Synchronous reset returns the block to idle with `phy_req`, `link_up` and `link_err` low. No PHY access follows until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| dbg0 | input | 32 | Training status word 0; low 6 bits are the training state |
| dbg1 | input | 32 | Training status word 1; bit 4 link established, bit 29 training |
| phy_done | input | 1 | One-cycle completion of the outstanding PHY access |
| phy_rdata | input | 16 | PHY read data, valid with `phy_done` |
| phy_req | output | 1 | PHY access request, held until done |
| phy_we | output | 1 | 1 for a write access, 0 for a read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| link_up | output | 1 | Sticky link-up flag |
| link_err | output | 1 | Sticky link timeout error |

## Verification
The bench builds the block with 2 ticks per microsecond, a 3 µs poll interval, a 10 µs hold and a limit of 6 polls. Polls are therefore 6 cycles apart, the override hold is 20 cycles, and the timeout path finishes in a few dozen cycles. At the default scale those paths would need millions of cycles. These values let one run cover the full recovery pulse, the spacing and hold bounds, the complete timeout count, an ignored mid-run start, and a reset taken in the middle of the hold.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RD_STAT,
      ST_RD_SET,
      ST_WR_SET,
      ST_HOLD,
      ST_RD_CLR,
      ST_WR_CLR,
      ST_WAIT
   } lsr_state_t;

   localparam int          UP_BIT       = 4;
   localparam int          TRAIN_BIT    = 29;
   localparam int          STATE_W      = 6;
   localparam logic [5:0]  RCVR_LOCK    = 6'h0D;
   localparam logic [15:0] OVR_MASK     = 16'h0028;

endpackage

// File: rtl/lsr_tick_timer.sv
module lsr_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;
   logic         run_q;

   assign expired = run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val - W'(1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - W'(1);
      end
   end

   a_r6_no_expire_on_load: assert property (@(posedge clk) disable iff (rst)
      load |=> !expired);

endmodule

// File: rtl/lsr_phy_port.sv
module lsr_phy_port #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic          go_we,
   input  logic [AW-1:0] go_addr,
   input  logic [DW-1:0] go_wdata,
   input  logic          phy_done,
   output logic          phy_req,
   output logic          phy_we,
   output logic [AW-1:0] phy_addr,
   output logic [DW-1:0] phy_wdata,
   output logic          op_done
);

   assign op_done = phy_req && phy_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         phy_req   <= 1'b0;
         phy_we    <= 1'b0;
         phy_addr  <= '0;
         phy_wdata <= '0;
      end else if (go) begin
         phy_req   <= 1'b1;
         phy_we    <= go_we;
         phy_addr  <= go_addr;
         phy_wdata <= go_wdata;
      end else if (phy_done) begin
         phy_req   <= 1'b0;
      end
   end

   a_r9_hold_until_done: assert property (@(posedge clk) disable iff (rst)
      (phy_req && !phy_done) |=> (phy_req && $stable(phy_addr) && $stable(phy_we)
                                  && $stable(phy_wdata)));

   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
      go |-> !phy_req);

endmodule

// File: rtl/link_stall_recovery.sv
module link_stall_recovery
   import lsr_pkg::*;
#(
   parameter int          TICKS_PER_US = 50,
   parameter int          POLL_US      = 10,
   parameter int          HOLD_US      = 3000,
   parameter int          MAX_POLLS    = 2000,
   parameter int          AW           = 16,
   parameter int          DW           = 16,
   parameter logic [15:0] STAT_ADDR    = 16'h100D,
   parameter logic [15:0] OVR_ADDR     = 16'h1005
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [31:0]   dbg0,
   input  logic [31:0]   dbg1,
   input  logic          phy_done,
   input  logic [DW-1:0] phy_rdata,
   output logic          phy_req,
   output logic          phy_we,
   output logic [AW-1:0] phy_addr,
   output logic [DW-1:0] phy_wdata,
   output logic          link_up,
   output logic          link_err
);

   localparam int POLL_CYC = POLL_US * TICKS_PER_US;
   localparam int HOLD_CYC = HOLD_US * TICKS_PER_US;
   localparam int MAX_CYC  = (POLL_CYC > HOLD_CYC) ? POLL_CYC : HOLD_CYC;
   localparam int TW       = $clog2(MAX_CYC + 1);
   localparam int PCW      = $clog2(MAX_POLLS + 1);

   generate
      if (TICKS_PER_US < 1) begin : g_bad_ticks
         $error("TICKS_PER_US must be at least 1");
      end
      if (POLL_US < 1 || HOLD_US < 1) begin : g_bad_intervals
         $error("POLL_US and HOLD_US must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
      if (AW < 16 || DW < 16) begin : g_bad_widths
         $error("PHY address and data ports must be at least 16 bits");
      end
   endgenerate

   lsr_state_t     state_q, state_n;
   logic           launch_q;
   logic [PCW-1:0] polls_q;
   logic [DW-1:0]  ovr_q;
   logic           op_done;
   logic           tmr_load;
   logic [TW-1:0]  tmr_val;
   logic           tmr_done;
   logic           link_ok;
   logic           stall_seen;
   logic           is_phy_n;
   logic           go_we;
   logic [AW-1:0]  go_addr;
   logic [DW-1:0]  go_wdata;

   wire unused_inputs = ^{dbg0[31:STATE_W], dbg1[31:30], dbg1[28:5], dbg1[3:0]};

   assign link_ok    = dbg1[UP_BIT] && !dbg1[TRAIN_BIT];
   assign stall_seen = !phy_rdata[0] && (dbg0[STATE_W-1:0] == RCVR_LOCK);

   always_comb begin
      state_n = state_q;
      unique case (state_q)
         ST_IDLE:    if (start) state_n = ST_CHECK;
         ST_CHECK:   state_n = link_ok ? ST_IDLE : ST_RD_STAT;
         ST_RD_STAT: if (op_done) state_n = stall_seen ? ST_RD_SET : ST_WAIT;
         ST_RD_SET:  if (op_done) state_n = ST_WR_SET;
         ST_WR_SET:  if (op_done) state_n = ST_HOLD;
         ST_HOLD:    if (tmr_done) state_n = ST_RD_CLR;
         ST_RD_CLR:  if (op_done) state_n = ST_WR_CLR;
         ST_WR_CLR:  if (op_done) state_n = ST_WAIT;
         ST_WAIT:    if (tmr_done)
                        state_n = (polls_q == PCW'(MAX_POLLS - 1)) ? ST_IDLE : ST_CHECK;
         default:    state_n = ST_IDLE;
      endcase
   end

   always_comb begin
      is_phy_n = 1'b0;
      case (state_n)
         ST_RD_STAT, ST_RD_SET, ST_WR_SET, ST_RD_CLR, ST_WR_CLR: is_phy_n = 1'b1;
         default: is_phy_n = 1'b0;
      endcase
   end

   assign tmr_load = (state_n != state_q) && (state_n == ST_HOLD || state_n == ST_WAIT);
   assign tmr_val  = (state_n == ST_HOLD) ? TW'(HOLD_CYC) : TW'(POLL_CYC);

   assign go_we    = (state_q == ST_WR_SET) || (state_q == ST_WR_CLR);
   assign go_addr  = (state_q == ST_RD_STAT) ? AW'(STAT_ADDR) : AW'(OVR_ADDR);
   assign go_wdata = go_we ? ovr_q : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         launch_q <= 1'b0;
         polls_q  <= '0;
         ovr_q    <= '0;
         link_up  <= 1'b0;
         link_err <= 1'b0;
      end else begin
         state_q  <= state_n;
         launch_q <= is_phy_n && (state_n != state_q);
         if (state_q == ST_IDLE && start) begin
            link_up  <= 1'b0;
            link_err <= 1'b0;
            polls_q  <= '0;
         end
         if (state_q == ST_CHECK && link_ok) link_up <= 1'b1;
         if (op_done && state_q == ST_RD_SET) ovr_q <= phy_rdata | DW'(OVR_MASK);
         if (op_done && state_q == ST_RD_CLR) ovr_q <= phy_rdata & ~DW'(OVR_MASK);
         if (state_q == ST_WAIT && tmr_done) begin
            polls_q <= polls_q + PCW'(1);
            if (polls_q == PCW'(MAX_POLLS - 1)) link_err <= 1'b1;
         end
      end
   end

   lsr_tick_timer #(.W(TW)) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   lsr_phy_port #(.AW(AW), .DW(DW)) port_i (
      .clk       (clk),
      .rst       (rst),
      .go        (launch_q),
      .go_we     (go_we),
      .go_addr   (go_addr),
      .go_wdata  (go_wdata),
      .phy_done  (phy_done),
      .phy_req   (phy_req),
      .phy_we    (phy_we),
      .phy_addr  (phy_addr),
      .phy_wdata (phy_wdata),
      .op_done   (op_done)
   );

   a_r1_up_needs_status: assert property (@(posedge clk) disable iff (rst)
      $rose(link_up) |-> $past(dbg1[UP_BIT] && !dbg1[TRAIN_BIT]));

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(link_up && link_err));

   a_r8_up_sticky: assert property (@(posedge clk) disable iff (rst)
      (link_up && !start) |=> link_up);

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
      (link_err && !start) |=> link_err);

   a_r4_writes_target_override: assert property (@(posedge clk) disable iff (rst)
      (phy_req && phy_we) |-> (phy_addr == AW'(OVR_ADDR)));

   a_r10_idle_after_reset: assert property (@(posedge clk)
      $past(rst) |-> (!phy_req && !link_up && !link_err));

endmodule

// File: tb/link_stall_recovery_tb_top.sv
module link_stall_recovery_tb_top;

   localparam int TPU       = 2;
   localparam int P_US      = 3;
   localparam int H_US      = 10;
   localparam int NPOLL     = 6;
   localparam int POLL_CYC  = P_US * TPU;
   localparam int HOLD_CYC  = H_US * TPU;
   localparam logic [15:0] SA = 16'h100D;
   localparam logic [15:0] OA = 16'h1005;

   typedef struct {
      bit          we;
      logic [15:0] addr;
      logic [15:0] data;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] dbg0 = '0;
   logic [31:0] dbg1 = '0;
   logic        phy_done = 1'b0;
   logic [15:0] phy_rdata = '0;
   logic        phy_req, phy_we, link_up, link_err;
   logic [15:0] phy_addr, phy_wdata;

   item_t       exp_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   int          dly = 0;
   logic [15:0] rx_word = 16'h0001;
   logic [15:0] ovr_reg = 16'h0041;
   int          last_stat = -1;
   int          set_cyc = -1;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   link_stall_recovery #(
      .TICKS_PER_US (TPU),
      .POLL_US      (P_US),
      .HOLD_US      (H_US),
      .MAX_POLLS    (NPOLL)
   ) dut_i (
      .clk (clk), .rst (rst), .start (start), .dbg0 (dbg0), .dbg1 (dbg1),
      .phy_done (phy_done), .phy_rdata (phy_rdata), .phy_req (phy_req),
      .phy_we (phy_we), .phy_addr (phy_addr), .phy_wdata (phy_wdata),
      .link_up (link_up), .link_err (link_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input bit we, input logic [15:0] addr,
                       input logic [15:0] data, input string req);
      item_t it;
      it.we = we; it.addr = addr; it.data = data; it.req = req;
      exp_q.push_back(it);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor and PHY model: pops the expected queue as accesses complete
   always @(negedge clk) begin
      if (phy_done) begin
         phy_done = 1'b0;
      end else if (phy_req) begin
         dly++;
         if (dly == 2) begin
            item_t it;
            dly = 0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected PHY access addr", {16'h0, phy_addr}, 32'h0);
            end else begin
               it = exp_q.pop_front();
               chk(phy_we == it.we, it.req, "access direction", {31'h0, phy_we}, {31'h0, it.we});
               chk(phy_addr == it.addr, it.req, "access address", {16'h0, phy_addr}, {16'h0, it.addr});
               if (it.we)
                  chk(phy_wdata == it.data, it.req, "write data", {16'h0, phy_wdata}, {16'h0, it.data});
            end
            if (!phy_we && phy_addr == SA) begin
               if (last_stat >= 0)
                  chk(cyc - last_stat >= POLL_CYC, "R6", "poll spacing", cyc - last_stat, POLL_CYC);
               last_stat = cyc;
            end
            if (!phy_we && phy_addr == OA && set_cyc >= 0) begin
               chk(cyc - set_cyc >= HOLD_CYC, "R5", "override hold", cyc - set_cyc, HOLD_CYC);
               set_cyc = -1;
            end
            if (phy_we) begin
               ovr_reg = phy_wdata;
               if ((phy_wdata & 16'h0028) == 16'h0028) set_cyc = cyc;
            end
            phy_rdata = (phy_addr == SA) ? rx_word : ovr_reg;
            phy_done  = 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(4);
      chk(phy_req == 1'b0, "R10", "req in reset", {31'h0, phy_req}, 32'h0);
      chk(link_up == 1'b0 && link_err == 1'b0, "R10", "flags in reset",
          {30'h0, link_up, link_err}, 32'h0);
      @(negedge clk) rst = 1'b0;

      // R1: established and not training -> up with no PHY access
      dbg1 = 32'h0000_0010;
      last_stat = -1;
      pulse_start();
      idle(4);
      chk(link_up == 1'b1, "R1", "immediate link up", {31'h0, link_up}, 32'h1);

      // R8: sticky after status drops
      dbg1 = 32'h0;
      idle(30);
      chk(link_up == 1'b1, "R8", "link up sticky", {31'h0, link_up}, 32'h1);

      // R1: training bit blocks link-up; R8 start clears flag
      dbg1 = 32'h2000_0010; rx_word = 16'h0001; dbg0 = 32'h0;
      push(1'b0, SA, 16'h0, "R2");
      last_stat = -1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(link_up == 1'b0, "R8", "start clears link_up", {31'h0, link_up}, 32'h0);
      drain();
      chk(link_up == 1'b0, "R1", "training bit blocks up", {31'h0, link_up}, 32'h0);
      dbg1 = 32'h0000_0010;
      idle(POLL_CYC + 6);
      chk(link_up == 1'b1, "R1", "up after training ends", {31'h0, link_up}, 32'h1);

      // R3: receive valid set -> no recovery even in recovery state
      dbg1 = 32'h0; dbg0 = 32'h0000_000D; rx_word = 16'h0001;
      push(1'b0, SA, 16'h0, "R3");
      last_stat = -1;
      pulse_start();
      drain();
      dbg1 = 32'h0000_0010;
      idle(POLL_CYC + 6);
      chk(link_up == 1'b1 && exp_q.size() == 0, "R3", "rx valid skips recovery",
          {31'h0, link_up}, 32'h1);

      // R3: other training state -> no recovery
      dbg1 = 32'h0; dbg0 = 32'h0000_000C; rx_word = 16'h0000;
      push(1'b0, SA, 16'h0, "R3");
      last_stat = -1;
      pulse_start();
      drain();
      dbg1 = 32'h0000_0010;
      idle(POLL_CYC + 6);
      chk(link_up == 1'b1, "R3", "other state skips recovery", {31'h0, link_up}, 32'h1);

      // R4/R5: stall recovery with upper debug bits set
      dbg1 = 32'h0; dbg0 = 32'hFFFF_FFCD; rx_word = 16'hFFFE; ovr_reg = 16'h0041;
      push(1'b0, SA, 16'h0, "R2");
      push(1'b0, OA, 16'h0, "R4");
      push(1'b1, OA, 16'h0069, "R4");
      push(1'b0, OA, 16'h0, "R5");
      push(1'b1, OA, 16'h0041, "R5");
      last_stat = -1;
      pulse_start();
      drain();
      dbg1 = 32'h0000_0010;
      idle(POLL_CYC + 6);
      chk(ovr_reg == 16'h0041, "R5", "override restored", {16'h0, ovr_reg}, 32'h41);
      chk(link_up == 1'b1, "R4", "up after recovery", {31'h0, link_up}, 32'h1);

      // R7: timeout after NPOLL polls; R8: mid-run start ignored
      dbg1 = 32'h0; dbg0 = 32'h0; rx_word = 16'h0001;
      for (int i = 0; i < NPOLL; i++) push(1'b0, SA, 16'h0, "R7");
      last_stat = -1;
      pulse_start();
      idle(10);
      pulse_start();
      while (!link_err) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "polls before timeout", exp_q.size(), 0);
      chk(link_up == 1'b0, "R7", "no link_up on timeout", {31'h0, link_up}, 32'h0);
      idle(30);
      chk(link_err == 1'b1, "R8", "error sticky", {31'h0, link_err}, 32'h1);
      chk(phy_req == 1'b0, "R7", "polling stopped", {31'h0, phy_req}, 32'h0);

      // R10: reset during the hold
      dbg0 = 32'h0000_000D; rx_word = 16'h0000; ovr_reg = 16'h0000;
      push(1'b0, SA, 16'h0, "R10");
      push(1'b0, OA, 16'h0, "R10");
      push(1'b1, OA, 16'h0028, "R10");
      last_stat = -1;
      pulse_start();
      drain();
      idle(3);
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk(phy_req == 1'b0 && link_err == 1'b0 && link_up == 1'b0, "R10",
          "idle after mid-run reset", {29'h0, phy_req, link_up, link_err}, 32'h0);
      set_cyc = -1;
      idle(HOLD_CYC + 20);
      chk(phy_req == 1'b0, "R10", "no access after reset", {31'h0, phy_req}, 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule